// File: doc/BRIEF.md
# UART automatic flow controller

This block runs UART flow control without software. It throttles the far end when the local receive FIFO fills, and it stops the local transmitter when the far end asks it to. Two kinds of control are supported. In-band control sends and recognises Xon and Xoff characters. Out-of-band control uses two independent modem-line handshake pairs: RTS#/CTS#, and DTR#/DSR#. Each of the three can be enabled alone or together with the others. The serialiser and the FIFOs sit outside the block.

On the receive side the block compares the receive FIFO level against a programmable upper and lower threshold. It keeps a throttle flag with hysteresis between the two. That flag drives RTS# and DTR# and, when in-band control is on, raises a request to send Xoff or Xon. On the transmit side, a received Xoff, or an inactive CTS#/DSR# input, stops new data characters. The stop takes effect only at a character boundary. Requests to send Xon or Xoff always go ahead of the next data character. The throttle, remote-Xoff and transmit-halt states can be read on status outputs.

Top module: `uart_flow_ctl`

## Requirements
- R1: One clock after a cycle in which the throttle flag is clear and `rx_level >= cfg_hi_thr`, `st_throttle` is 1.
- R2: One clock after a cycle in which the throttle flag is set and `rx_level <= cfg_lo_thr`, `st_throttle` is 0. In every other cycle the flag holds its value.
- R3: `rts_n` equals `st_throttle` when `cfg_rtscts_en` is 1, and 0 otherwise. `dtr_n` does the same under `cfg_dsrdtr_en`.
- R4: When `cfg_sw_en` is 1, a rising throttle flag sets `ins_xoff_req` and clears `ins_xon_req`. A falling flag does the reverse. A request stays set until `ins_ack` is 1 in a cycle with no new throttle edge. Both requests are 0 while `cfg_sw_en` is 0, and the two are never 1 together.
- R5: With `cfg_sw_en` at 1, a received character equal to `cfg_xoff_char` sets `st_remote_xoff` on the next clock, and one equal to `cfg_xon_char` clears it. If a character matches both, Xoff wins. While `cfg_sw_en` is 0 the flag clears.
- R6: `rx_fwd_valid` equals `rx_valid`, except that it is 0 for an Xon or Xoff character while `cfg_sw_en` is 1. `rx_fwd_data` always equals `rx_data`.
- R7: `st_tx_halted` takes a new value only on a clock where `tx_busy` is 0 or `tx_char_done` is 1. The new value is the halt request: remote Xoff, or an inactive handshake input of an enabled pair.
- R8: `cts_n` and `dsr_n` pass through a two-flop synchroniser that resets to 1 (inactive). A high `cts_n` requests a halt only under `cfg_rtscts_en`, and a high `dsr_n` only under `cfg_dsrdtr_en`.
- R9: `tx_data_en` is 1 only when `st_tx_halted` is 0 and neither insertion request is pending.
- R10: During reset `st_throttle`, `st_remote_xoff`, `st_tx_halted`, `ins_xon_req`, `ins_xoff_req`, `rts_n` and `dtr_n` are all 0, and `tx_data_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sw_en | input | 1 | Enable in-band Xon/Xoff control |
| cfg_rtscts_en | input | 1 | Enable the RTS#/CTS# pair |
| cfg_dsrdtr_en | input | 1 | Enable the DTR#/DSR# pair |
| cfg_xon_char | input | CW | Xon character value |
| cfg_xoff_char | input | CW | Xoff character value |
| cfg_hi_thr | input | LW | Upper threshold, in FIFO entries |
| cfg_lo_thr | input | LW | Lower threshold, in FIFO entries |
| rx_level | input | LW | Receive FIFO fill level |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CW | Received character |
| rx_fwd_valid | output | 1 | Write strobe to the receive FIFO |
| rx_fwd_data | output | CW | Character to the receive FIFO |
| cts_n | input | 1 | Active-low clear-to-send from the line |
| dsr_n | input | 1 | Active-low data-set-ready from the line |
| tx_busy | input | 1 | Serialiser is sending a character |
| tx_char_done | input | 1 | Serialiser finishes a character this cycle |
| ins_ack | input | 1 | Serialiser has taken the pending Xon/Xoff request |
| tx_data_en | output | 1 | Serialiser may start the next data character |
| ins_xon_req | output | 1 | Request to send Xon |
| ins_xoff_req | output | 1 | Request to send Xoff |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low data-terminal-ready |
| st_throttle | output | 1 | Receive side is throttling the far end |
| st_remote_xoff | output | 1 | Far end has sent Xoff |
| st_tx_halted | output | 1 | Data transmission is stopped |

## Verification
The assertions take for granted that the lower threshold lies below the upper one. Without that the hysteresis rules overlap and the release property would be contradicted. They also take for granted that `tx_char_done` is raised only while `tx_busy` is high. The bench keeps to these rules: each phase draws `cfg_lo_thr` strictly below `cfg_hi_thr`, and it derives `tx_char_done` from `tx_busy`. It changes configuration only at phase boundaries, and it drives `ins_ack` only while a request from its own model is pending.

// File: rtl/uart_flow_ctl.sv
`timescale 1ns/1ps
module uart_flow_ctl #(
  parameter int DEPTH = 128,
  parameter int CW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sw_en,
  input  logic          cfg_rtscts_en,
  input  logic          cfg_dsrdtr_en,
  input  logic [CW-1:0] cfg_xon_char,
  input  logic [CW-1:0] cfg_xoff_char,
  input  logic [LW-1:0] cfg_hi_thr,
  input  logic [LW-1:0] cfg_lo_thr,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  output logic          rx_fwd_valid,
  output logic [CW-1:0] rx_fwd_data,
  input  logic          cts_n,
  input  logic          dsr_n,
  input  logic          tx_busy,
  input  logic          tx_char_done,
  input  logic          ins_ack,
  output logic          tx_data_en,
  output logic          ins_xon_req,
  output logic          ins_xoff_req,
  output logic          rts_n,
  output logic          dtr_n,
  output logic          st_throttle,
  output logic          st_remote_xoff,
  output logic          st_tx_halted
);

  logic       thr_q, thr_d, pxon_q, pxoff_q, rxoff_q, halt_q;
  logic [1:0] cts_s, dsr_s;

  wire is_xon   = cfg_sw_en && (rx_data == cfg_xon_char);
  wire is_xoff  = cfg_sw_en && (rx_data == cfg_xoff_char);
  wire thr_rise = thr_d && !thr_q;
  wire thr_fall = !thr_d && thr_q;
  wire want_halt = rxoff_q || (cfg_rtscts_en && cts_s[1]) || (cfg_dsrdtr_en && dsr_s[1]);
  wire boundary  = !tx_busy || tx_char_done;

  always_comb begin
    thr_d = thr_q;
    if (!thr_q && rx_level >= cfg_hi_thr)
      thr_d = 1'b1;
    else if (thr_q && rx_level <= cfg_lo_thr)
      thr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= 1'b0;
      pxon_q  <= 1'b0;
      pxoff_q <= 1'b0;
      rxoff_q <= 1'b0;
      halt_q  <= 1'b0;
      cts_s   <= 2'b11;
      dsr_s   <= 2'b11;
    end else begin
      thr_q <= thr_d;
      cts_s <= {cts_s[0], cts_n};
      dsr_s <= {dsr_s[0], dsr_n};

      if (!cfg_sw_en) begin
        pxon_q  <= 1'b0;
        pxoff_q <= 1'b0;
      end else if (thr_rise) begin
        pxoff_q <= 1'b1;
        pxon_q  <= 1'b0;
      end else if (thr_fall) begin
        pxon_q  <= 1'b1;
        pxoff_q <= 1'b0;
      end else if (ins_ack) begin
        pxon_q  <= 1'b0;
        pxoff_q <= 1'b0;
      end

      if (!cfg_sw_en)
        rxoff_q <= 1'b0;
      else if (rx_valid && is_xoff)
        rxoff_q <= 1'b1;
      else if (rx_valid && is_xon)
        rxoff_q <= 1'b0;

      if (boundary)
        halt_q <= want_halt;
    end
  end

  assign rx_fwd_valid   = rx_valid && !(is_xon || is_xoff);
  assign rx_fwd_data    = rx_data;
  assign ins_xon_req    = pxon_q;
  assign ins_xoff_req   = pxoff_q;
  assign tx_data_en     = !halt_q && !pxon_q && !pxoff_q;
  assign rts_n          = cfg_rtscts_en && thr_q;
  assign dtr_n          = cfg_dsrdtr_en && thr_q;
  assign st_throttle    = thr_q;
  assign st_remote_xoff = rxoff_q;
  assign st_tx_halted   = halt_q;

  AST_THROTTLE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_throttle && rx_level >= cfg_hi_thr) |=> st_throttle); // R1

  AST_THROTTLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_throttle && rx_level <= cfg_lo_thr) |=> !st_throttle); // R2

  AST_XOFF_ON_THROTTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_en && !st_throttle && rx_level >= cfg_hi_thr) |=> ins_xoff_req); // R4

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_xon_req && ins_xoff_req)); // R4

  AST_RX_XOFF_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_en && rx_valid && rx_data == cfg_xoff_char) |=> st_remote_xoff); // R5

  AST_CTRL_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_en && rx_valid && (rx_data == cfg_xoff_char || rx_data == cfg_xon_char)) |-> !rx_fwd_valid); // R6

  AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_char_done) |=> $stable(st_tx_halted)); // R7

  AST_PRIO_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_xon_req || ins_xoff_req) |-> !tx_data_en); // R9

endmodule

// File: tb/tb_uart_flow_ctl.sv
`timescale 1ns/1ps
module tb_uart_flow_ctl;
  localparam int DEPTH = 128;
  localparam int CW = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sw_en = 0, cfg_rtscts_en = 0, cfg_dsrdtr_en = 0;
  logic [CW-1:0] cfg_xon_char = 8'h11, cfg_xoff_char = 8'h13;
  logic [LW-1:0] cfg_hi_thr = 96, cfg_lo_thr = 32, rx_level = 0;
  logic rx_valid = 0;
  logic [CW-1:0] rx_data = 0;
  logic cts_n = 1, dsr_n = 1, tx_busy = 0, tx_char_done = 0, ins_ack = 0;
  logic rx_fwd_valid, tx_data_en, ins_xon_req, ins_xoff_req, rts_n, dtr_n;
  logic st_throttle, st_remote_xoff, st_tx_halted;
  logic [CW-1:0] rx_fwd_data;

  always #4 clk = ~clk;

  uart_flow_ctl #(.DEPTH(DEPTH), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_sw_en(cfg_sw_en), .cfg_rtscts_en(cfg_rtscts_en),
    .cfg_dsrdtr_en(cfg_dsrdtr_en), .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
    .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .rx_level(rx_level),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_fwd_valid(rx_fwd_valid), .rx_fwd_data(rx_fwd_data),
    .cts_n(cts_n), .dsr_n(dsr_n), .tx_busy(tx_busy), .tx_char_done(tx_char_done),
    .ins_ack(ins_ack), .tx_data_en(tx_data_en), .ins_xon_req(ins_xon_req),
    .ins_xoff_req(ins_xoff_req), .rts_n(rts_n), .dtr_n(dtr_n), .st_throttle(st_throttle),
    .st_remote_xoff(st_remote_xoff), .st_tx_halted(st_tx_halted));

  int compared = 0, mismatched = 0;
  bit m_thr, m_pxon, m_pxoff, m_rxoff, m_halt;
  bit cts_q[$], dsr_q[$];

  task automatic chk(input logic act, input bit exp, input string req, input string nm);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_thr = 0; m_pxon = 0; m_pxoff = 0; m_rxoff = 0; m_halt = 0;
    cts_q = '{1'b1, 1'b1};
    dsr_q = '{1'b1, 1'b1};
  endtask

  task automatic model_step();
    bit nthr, want;
    int lvl = int'(rx_level);
    nthr = m_thr;
    if (!m_thr && lvl >= int'(cfg_hi_thr)) nthr = 1;
    else if (m_thr && lvl <= int'(cfg_lo_thr)) nthr = 0;
    // R8: the synchronised line value is the oldest queue entry
    want = m_rxoff || (cfg_rtscts_en && cts_q[0]) || (cfg_dsrdtr_en && dsr_q[0]);
    if (!cfg_sw_en) begin m_pxon = 0; m_pxoff = 0; end
    else if (nthr && !m_thr) begin m_pxoff = 1; m_pxon = 0; end
    else if (!nthr && m_thr) begin m_pxon = 1; m_pxoff = 0; end
    else if (ins_ack) begin m_pxon = 0; m_pxoff = 0; end
    if (!cfg_sw_en) m_rxoff = 0;
    else if (rx_valid && rx_data == cfg_xoff_char) m_rxoff = 1;
    else if (rx_valid && rx_data == cfg_xon_char) m_rxoff = 0;
    if (!tx_busy || tx_char_done) m_halt = want;
    m_thr = nthr;
    void'(cts_q.pop_front()); cts_q.push_back(cts_n);
    void'(dsr_q.pop_front()); dsr_q.push_back(dsr_n);
  endtask

  task automatic compare_all();
    bit ctl = cfg_sw_en && (rx_data == cfg_xon_char || rx_data == cfg_xoff_char);
    chk(st_throttle, m_thr, "R1 R2", "st_throttle");
    chk(rts_n, cfg_rtscts_en && m_thr, "R3", "rts_n");
    chk(dtr_n, cfg_dsrdtr_en && m_thr, "R3", "dtr_n");
    chk(ins_xoff_req, m_pxoff, "R4", "ins_xoff_req");
    chk(ins_xon_req, m_pxon, "R4", "ins_xon_req");
    chk(st_remote_xoff, m_rxoff, "R5", "st_remote_xoff");
    chk(rx_fwd_valid, rx_valid && !ctl, "R6", "rx_fwd_valid");
    compared++;
    if (rx_fwd_data !== rx_data) begin
      mismatched++;
      $display("FAIL R6 rx_fwd_data actual=%h expected=%h", rx_fwd_data, rx_data);
    end
    chk(st_tx_halted, m_halt, "R7 R8", "st_tx_halted");
    chk(tx_data_en, !m_halt && !m_pxon && !m_pxoff, "R9", "tx_data_en");
  endtask

  task automatic drive(input int phase);
    int r = int'($urandom_range(0, 9));
    int lvl = int'(rx_level);
    if (r == 0) lvl = int'(cfg_hi_thr);
    else if (r == 1) lvl = int'(cfg_lo_thr);
    else lvl = lvl + int'($urandom_range(0, 6)) - 3;
    if (lvl < 0) lvl = 0;
    if (lvl > DEPTH) lvl = DEPTH;
    rx_level = LW'(lvl);
    rx_valid = ($urandom_range(0, 2) == 0);
    case ($urandom_range(0, 3))
      0: rx_data = cfg_xon_char;
      1: rx_data = cfg_xoff_char;
      default: rx_data = CW'($urandom);
    endcase
    if ($urandom_range(0, 15) == 0) cts_n = ~cts_n;
    if ($urandom_range(0, 15) == 0) dsr_n = ~dsr_n;
    tx_busy = ($urandom_range(0, 2) != 0);
    tx_char_done = tx_busy && ($urandom_range(0, 3) == 0);
    ins_ack = (m_pxon || m_pxoff) && ($urandom_range(0, 3) == 0);
    if (phase == 5) begin
      tx_busy = 1;
      tx_char_done = 0;
    end
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(7));
    model_reset();
    cfg_sw_en = 1; cfg_rtscts_en = 1; cfg_dsrdtr_en = 1; rx_level = 128;
    repeat (3) @(negedge clk);
    // R10: reset values with every mode enabled and a full FIFO
    chk(st_throttle, 0, "R10", "st_throttle");
    chk(st_remote_xoff, 0, "R10", "st_remote_xoff");
    chk(st_tx_halted, 0, "R10", "st_tx_halted");
    chk(ins_xon_req, 0, "R10", "ins_xon_req");
    chk(ins_xoff_req, 0, "R10", "ins_xoff_req");
    chk(rts_n, 0, "R10", "rts_n");
    chk(dtr_n, 0, "R10", "dtr_n");
    chk(tx_data_en, 1, "R10", "tx_data_en");
    rx_level = 0;
    rst_n = 1;
    for (int ph = 0; ph < 7; ph++) begin
      case (ph)
        0: begin cfg_sw_en = 1; cfg_rtscts_en = 0; cfg_dsrdtr_en = 0; cfg_hi_thr = 96;  cfg_lo_thr = 32; end
        1: begin cfg_sw_en = 0; cfg_rtscts_en = 1; cfg_dsrdtr_en = 0; cfg_hi_thr = 128; cfg_lo_thr = 0;  end
        2: begin cfg_sw_en = 0; cfg_rtscts_en = 0; cfg_dsrdtr_en = 1; cfg_hi_thr = 1;   cfg_lo_thr = 0;  end
        3: begin cfg_sw_en = 1; cfg_rtscts_en = 1; cfg_dsrdtr_en = 1; cfg_hi_thr = 10;  cfg_lo_thr = 5;  end
        4: begin cfg_sw_en = 0; cfg_rtscts_en = 0; cfg_dsrdtr_en = 0; cfg_hi_thr = 64;  cfg_lo_thr = 63; end
        5: begin cfg_sw_en = 1; cfg_rtscts_en = 1; cfg_dsrdtr_en = 0; cfg_hi_thr = 8;   cfg_lo_thr = 2;  end
        default: begin
          cfg_sw_en = 1; cfg_rtscts_en = 1; cfg_dsrdtr_en = 1;
          cfg_hi_thr = LW'($urandom_range(2, DEPTH));
          cfg_lo_thr = LW'($urandom_range(0, int'(cfg_hi_thr) - 1));
          cfg_xon_char = 8'hA5; cfg_xoff_char = 8'hA5;
        end
      endcase
      for (int c = 0; c < 1500; c++) begin
        drive(ph);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule